// File: doc/BRIEF.md
# Flash Embedded Operation Status Reporter

This block sits beside a flash array and stands in for the array's internal program and erase engine. When a start request arrives with an operation code, a target address and a data byte, the block holds a busy period whose length is set by a parameter for each operation type. At the end of that period it issues the array update: a byte program, a sector erase, or a chip erase that walks the sectors one at a time.

While the operation runs, the block rewrites what a host read returns, so that software can tell when the operation has finished using only the data bus. The poll bit reads as the complement of the value that the target will finally hold. The toggle bit changes on every read strobe. All other bits pass the array's data straight through. Once the block is idle, reads pass through unchanged. Command decoding and the host bus sit outside this block. The array is external, and the block drives it through a program strobe and a sector fill strobe.

Top module: `flash_op_status`

## Requirements
- R1: After reset the block is idle. `busy_o` is 0, `arr_pgm_o` and `arr_fill_o` are 0, and `rdata_o` equals `arr_rdata_i`.
- R2: A start is taken on a clock edge where `start_i` is 1 and the block is idle. `op_i` codes are 2'b01 program, 2'b10 sector erase, 2'b11 chip erase and 2'b00 no operation. A no-operation start leaves the block idle. `busy_o` rises in the cycle after the edge that accepted the start.
- R3: A program keeps `busy_o` high for PROG_CYC cycles. In the last busy cycle it pulses `arr_pgm_o` for one cycle with the latched address and data. The array then stores the old byte ANDed with that data, so bits can only go from 1 to 0.
- R4: While busy, bit 7 of `rdata_o` reads as the complement of the target's final bit 7. For a program this is the inverse of data bit 7. For an erase it is 0. Bits 5..0 pass through from `arr_rdata_i`.
- R5: Bit 6 of `rdata_o` comes from a flag that is 0 after reset. The flag inverts on each clock edge where `rd_i` is 1 while busy. It holds its value while idle.
- R6: While idle, every bit of `rdata_o` equals `arr_rdata_i`. Repeated reads return the same value.
- R7: A sector erase targets the sector given by the top SECT_W address bits. It stays busy for SECT_CYC cycles. In the last busy cycle it pulses `arr_fill_o` with fill value all ones for that sector.
- R8: A chip erase first fills sectors 0 to N-1 with zeros, one sector every ZERO_CYC cycles. It then fills sectors 0 to N-1 with all ones, one sector every SECT_CYC cycles. The busy period is N*(ZERO_CYC+SECT_CYC) cycles.
- R9: A start request that arrives while busy is ignored. This includes a program during an erase. It does not change the target, the array or the remaining busy time.
- R10: Each accepted start reloads the duration counter. Back-to-back operations each get their full duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| op_i | input | 2 | Operation code |
| addr_i | input | ADDR_W | Target byte address (its top bits select the sector for a sector erase) |
| data_i | input | DATA_W | Data to program |
| rd_i | input | 1 | Host read strobe, one cycle per read |
| arr_rdata_i | input | DATA_W | Array data at the host read address |
| busy_o | output | 1 | Operation in progress |
| rdata_o | output | DATA_W | Read data after status override |
| arr_pgm_o | output | 1 | One-cycle array program strobe |
| arr_addr_o | output | ADDR_W | Program address |
| arr_data_o | output | DATA_W | Program data, ANDed into the array |
| arr_fill_o | output | 1 | One-cycle sector fill strobe |
| arr_fill_val_o | output | DATA_W | Fill value (all zeros or all ones) |
| arr_sect_o | output | SECT_W | Sector index for the fill |

## Verification
On every cycle, the embedded assertions check the following. `busy_o` rises only after a start. An array strobe appears only while busy, and never two strobes at once. Every busy period ends on an array action. A start that arrives while busy leaves the latched target untouched. The toggle flag inverts on each busy read and holds while idle. The exact busy lengths can only be shown by the bench's directed scenarios. The same is true of the order and timing of the chip erase's zero and fill passes, the AND rule for programming, and the read values seen during and after each operation.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_PROG = 2'b01,
      OP_SECT = 2'b10,
      OP_CHIP = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PROG,
      PH_ZERO,
      PH_ERASE
   } phase_e;

endpackage

// File: rtl/op_timer.sv
module op_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             expire_o
);

   logic [CNT_W-1:0] cnt_q;

   // Load takes priority over counting, so the count restarts on every new phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = run_i && (cnt_q == '0);

   // R10: a running count never jumps up unless it is reloaded
   a_r10_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && run_i) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
   import flash_op_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int SECT_W   = 8,
   parameter int PROG_CYC = 20,
   parameter int SECT_CYC = 500,
   parameter int ZERO_CYC = 40,
   parameter int POLL_BIT = 7,
   parameter int CNT_W    = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              expire_i,
   output logic              busy_o,
   output logic              load_o,
   output logic [CNT_W-1:0]  load_val_o,
   output logic              ref_bit_o,
   output logic              arr_pgm_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [DATA_W-1:0] arr_data_o,
   output logic              arr_fill_o,
   output logic [DATA_W-1:0] arr_fill_val_o,
   output logic [SECT_W-1:0] arr_sect_o
);

   localparam logic [SECT_W-1:0] LAST_SECT = '1;
   localparam logic [CNT_W-1:0]  PROG_LD   = CNT_W'(PROG_CYC - 1);
   localparam logic [CNT_W-1:0]  SECT_LD   = CNT_W'(SECT_CYC - 1);
   localparam logic [CNT_W-1:0]  ZERO_LD   = CNT_W'(ZERO_CYC - 1);

   phase_e            ph_q, ph_d;
   logic              chip_q;
   logic [SECT_W-1:0] sect_q, sect_d;
   logic [ADDR_W-1:0] tgt_addr_q;
   logic [DATA_W-1:0] tgt_data_q;
   op_e               op_w;
   logic              accept;

   assign op_w   = op_e'(op_i);
   assign accept = start_i && (ph_q == PH_IDLE) && (op_w != OP_NONE);

   always_comb begin
      ph_d           = ph_q;
      sect_d         = sect_q;
      load_o         = 1'b0;
      load_val_o     = PROG_LD;
      arr_pgm_o      = 1'b0;
      arr_fill_o     = 1'b0;
      arr_fill_val_o = '1;
      case (ph_q)
         PH_IDLE: begin
            if (accept) begin
               load_o = 1'b1;
               case (op_w)
                  OP_PROG: begin
                     ph_d       = PH_PROG;
                     load_val_o = PROG_LD;
                  end
                  OP_SECT: begin
                     ph_d       = PH_ERASE;
                     sect_d     = addr_i[ADDR_W-1 -: SECT_W];
                     load_val_o = SECT_LD;
                  end
                  default: begin
                     ph_d       = PH_ZERO;
                     sect_d     = '0;
                     load_val_o = ZERO_LD;
                  end
               endcase
            end
         end
         PH_PROG: begin
            if (expire_i) begin
               arr_pgm_o = 1'b1;
               ph_d      = PH_IDLE;
            end
         end
         PH_ZERO: begin
            if (expire_i) begin
               arr_fill_o     = 1'b1;
               arr_fill_val_o = '0;
               load_o         = 1'b1;
               if (sect_q == LAST_SECT) begin
                  ph_d       = PH_ERASE;
                  sect_d     = '0;
                  load_val_o = SECT_LD;
               end else begin
                  sect_d     = sect_q + SECT_W'(1);
                  load_val_o = ZERO_LD;
               end
            end
         end
         default: begin
            if (expire_i) begin
               arr_fill_o     = 1'b1;
               arr_fill_val_o = '1;
               if (chip_q && (sect_q != LAST_SECT)) begin
                  sect_d     = sect_q + SECT_W'(1);
                  load_o     = 1'b1;
                  load_val_o = SECT_LD;
               end else begin
                  ph_d = PH_IDLE;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         sect_q     <= '0;
         chip_q     <= 1'b0;
         tgt_addr_q <= '0;
         tgt_data_q <= '0;
      end else begin
         ph_q   <= ph_d;
         sect_q <= sect_d;
         if (accept) begin
            chip_q     <= (op_w == OP_CHIP);
            tgt_addr_q <= addr_i;
            tgt_data_q <= data_i;
         end
      end
   end

   assign busy_o     = (ph_q != PH_IDLE);
   assign ref_bit_o  = (ph_q == PH_PROG) ? tgt_data_q[POLL_BIT] : 1'b1;
   assign arr_addr_o = tgt_addr_q;
   assign arr_data_o = tgt_data_q;
   assign arr_sect_o = sect_q;

   // R2: busy only ever begins after a start request
   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R3: array strobes only inside a busy period
   a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_pgm_o || arr_fill_o) |-> busy_o);

   // R3: never a program and a fill in the same cycle
   a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_pgm_o && arr_fill_o));

   // R3: every busy period closes on an array action
   a_r3_end_on_action: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(arr_pgm_o || arr_fill_o));

   // R9: a start while busy leaves the latched target alone
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(tgt_addr_q) && $stable(tgt_data_q)));

endmodule

// File: rtl/status_mux.sv
module status_mux #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              rd_i,
   input  logic              ref_bit_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic tgl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_q <= 1'b0;
      end else if (busy_i && rd_i) begin
         tgl_q <= ~tgl_q;
      end
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign rdata_o[b] = busy_i ? ~ref_bit_i : arr_rdata_i[b];
      end else if (b == TOGGLE_BIT) begin : g_tgl
         assign rdata_o[b] = busy_i ? tgl_q : arr_rdata_i[b];
      end else begin : g_pass
         assign rdata_o[b] = arr_rdata_i[b];
      end
   end

   // R5: every busy read inverts the toggle flag
   a_r5_toggle_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && rd_i) |=> (tgl_q != $past(tgl_q)));

   // R5: the flag holds while idle
   a_r5_toggle_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_i |=> $stable(tgl_q));

endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
   import flash_op_pkg::*;
#(
   parameter int ADDR_W     = 17,
   parameter int DATA_W     = 8,
   parameter int SECT_W     = 8,
   parameter int PROG_CYC   = 20,
   parameter int SECT_CYC   = 500,
   parameter int ZERO_CYC   = 40,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] arr_rdata_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              arr_pgm_o,
   output logic [ADDR_W-1:0] arr_addr_o,
   output logic [DATA_W-1:0] arr_data_o,
   output logic              arr_fill_o,
   output logic [DATA_W-1:0] arr_fill_val_o,
   output logic [SECT_W-1:0] arr_sect_o
);

   localparam int MAX_PS  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
   localparam int MAX_CYC = (MAX_PS > ZERO_CYC) ? MAX_PS : ZERO_CYC;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   if (PROG_CYC < 1 || SECT_CYC < 1 || ZERO_CYC < 1) begin : g_bad_cyc
      $error("durations must be at least one cycle");
   end
   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_bad_sect
      $error("SECT_W must lie in 1..ADDR_W-1");
   end
   if (DATA_W < 2 || POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W ||
       POLL_BIT == TOGGLE_BIT) begin : g_bad_bits
      $error("status bit positions invalid for DATA_W");
   end

   logic             load_w;
   logic [CNT_W-1:0] load_val_w;
   logic             expire_w;
   logic             ref_bit_w;
   logic             busy_w;

   op_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_w),
      .load_val_i (load_val_w),
      .run_i      (busy_w),
      .expire_o   (expire_w)
   );

   op_sequencer #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SECT_W   (SECT_W),
      .PROG_CYC (PROG_CYC),
      .SECT_CYC (SECT_CYC),
      .ZERO_CYC (ZERO_CYC),
      .POLL_BIT (POLL_BIT),
      .CNT_W    (CNT_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .op_i           (op_i),
      .addr_i         (addr_i),
      .data_i         (data_i),
      .expire_i       (expire_w),
      .busy_o         (busy_w),
      .load_o         (load_w),
      .load_val_o     (load_val_w),
      .ref_bit_o      (ref_bit_w),
      .arr_pgm_o      (arr_pgm_o),
      .arr_addr_o     (arr_addr_o),
      .arr_data_o     (arr_data_o),
      .arr_fill_o     (arr_fill_o),
      .arr_fill_val_o (arr_fill_val_o),
      .arr_sect_o     (arr_sect_o)
   );

   status_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_mux (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_w),
      .rd_i        (rd_i),
      .ref_bit_i   (ref_bit_w),
      .arr_rdata_i (arr_rdata_i),
      .rdata_o     (rdata_o)
   );

   assign busy_o = busy_w;

endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;

   localparam int AW = 6;
   localparam int DW = 8;
   localparam int SW = 2;
   localparam int NS = 4;
   localparam int PC = 6;
   localparam int SC = 7;
   localparam int ZC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = 2'b00;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] data_i = '0;
   logic          rd_i = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] arr_rdata;
   logic          busy_o;
   logic [DW-1:0] rdata_o;
   logic          arr_pgm_o;
   logic [AW-1:0] arr_addr_o;
   logic [DW-1:0] arr_data_o;
   logic          arr_fill_o;
   logic [DW-1:0] arr_fill_val_o;
   logic [SW-1:0] arr_sect_o;

   logic [DW-1:0] mem [2**AW];
   int checks = 0;
   int failures = 0;
   logic tgl_exp = 1'b0;

   always #5 clk = ~clk;

   flash_op_status #(
      .ADDR_W(AW), .DATA_W(DW), .SECT_W(SW),
      .PROG_CYC(PC), .SECT_CYC(SC), .ZERO_CYC(ZC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .addr_i(addr_i), .data_i(data_i), .rd_i(rd_i), .arr_rdata_i(arr_rdata),
      .busy_o(busy_o), .rdata_o(rdata_o), .arr_pgm_o(arr_pgm_o),
      .arr_addr_o(arr_addr_o), .arr_data_o(arr_data_o), .arr_fill_o(arr_fill_o),
      .arr_fill_val_o(arr_fill_val_o), .arr_sect_o(arr_sect_o)
   );

   // behavioural array: program ANDs, fill writes a whole sector
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2**AW; i++) mem[i] <= 8'hFF;
      end else begin
         if (arr_pgm_o) mem[arr_addr_o] <= mem[arr_addr_o] & arr_data_o;
         if (arr_fill_o)
            for (int i = 0; i < 16; i++) mem[{arr_sect_o, 4'(i)}] <= arr_fill_val_o;
      end
   end
   assign arr_rdata = mem[rd_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      start_i = 1'b1; op_i = op; addr_i = a; data_i = d;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // one-cycle read; tracks the expected toggle flag
   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] v, output logic [DW-1:0] arr, output logic b);
      @(negedge clk);
      rd_addr = a; rd_i = 1'b1;
      #1;
      v = rdata_o; arr = mem[a]; b = busy_o;
      @(posedge clk);
      #1 rd_i = 1'b0;
      if (b) tgl_exp = ~tgl_exp;
   endtask

   function automatic logic [DW-1:0] busy_view(input logic [DW-1:0] arr, input logic fin7, input logic t);
      return {~fin7, t, arr[5:0]};
   endfunction

   task automatic wait_idle(output int n);
      n = 0;
      while (busy_o && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic t_reset();
      logic [DW-1:0] v, arr; logic b;
      check(busy_o == 1'b0, "R1 busy", busy_o, 0);
      check(arr_pgm_o == 1'b0 && arr_fill_o == 1'b0, "R1 strobes", {arr_pgm_o, arr_fill_o}, 0);
      do_read(6'h05, v, arr, b);
      check(v == 8'hFF, "R1 read", v, 8'hFF);
   endtask

   task automatic t_nop();
      start_op(2'b00, 6'h01, 8'h00);
      check(busy_o == 1'b0, "R2 nop busy", busy_o, 0);
      @(negedge clk);
      check(busy_o == 1'b0 && !arr_pgm_o && !arr_fill_o, "R2 nop idle", busy_o, 0);
   endtask

   task automatic t_program_poll();
      logic [DW-1:0] v, arr, exp; logic b; int n;
      start_op(2'b01, 6'h05, 8'hDA);
      check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      do_read(6'h05, v, arr, b);
      exp = busy_view(arr, 1'b1, ~tgl_exp);
      check(b && v == exp, "R4 poll bit program", v, exp);
      do_read(6'h05, v, arr, b);
      exp = busy_view(arr, 1'b1, ~tgl_exp);
      check(b && v == exp, "R5 toggle second read", v, exp);
      wait_idle(n);
      do_read(6'h05, v, arr, b);
      check(v == 8'hDA, "R3 programmed value", v, 8'hDA);
      start_op(2'b01, 6'h05, 8'h3F);
      do_read(6'h05, v, arr, b);
      exp = busy_view(arr, 1'b0, ~tgl_exp);
      check(b && v == exp, "R4 poll bit zero data", v, exp);
      wait_idle(n);
      do_read(6'h05, v, arr, b);
      check(v == 8'h1A, "R3 AND rule", v, 8'h1A);
   endtask

   task automatic t_prog_timing(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
      logic [DW-1:0] v, arr; logic b;
      start_op(2'b01, a, d);
      check(busy_o && !arr_pgm_o, {tag, " first busy cycle"}, busy_o, 1);
      repeat (PC - 2) @(negedge clk);
      check(busy_o && !arr_pgm_o, {tag, " no early strobe"}, arr_pgm_o, 0);
      @(negedge clk);
      check(busy_o && arr_pgm_o && arr_addr_o == a && arr_data_o == d,
            {tag, " strobe in last cycle"}, {arr_pgm_o, arr_addr_o}, {1'b1, a});
      @(negedge clk);
      check(!busy_o, {tag, " busy length"}, busy_o, 0);
      do_read(a, v, arr, b);
      check(v == d, {tag, " stored"}, v, d);
   endtask

   task automatic t_sector_erase();
      int cyc; int fcyc; logic [DW-1:0] fval; logic [SW-1:0] fsec;
      logic [DW-1:0] v, arr; logic b; int n;
      start_op(2'b01, 6'h26, 8'h00);
      wait_idle(n);
      start_op(2'b10, 6'h25, 8'h00);
      cyc = 1; fcyc = -1; fval = '0; fsec = '0;
      while (busy_o && cyc < 500) begin
         if (arr_fill_o) begin fcyc = cyc; fval = arr_fill_val_o; fsec = arr_sect_o; end
         @(negedge clk);
         cyc++;
      end
      check(cyc - 1 == SC, "R7 erase length", cyc - 1, SC);
      check(fcyc == SC && fval == 8'hFF && fsec == 2'd2, "R7 fill sector 2", {fcyc, fsec}, {SC, 2'd2});
      do_read(6'h26, v, arr, b);
      check(v == 8'hFF, "R7 sector erased", v, 8'hFF);
      do_read(6'h05, v, arr, b);
      check(v == 8'h1A, "R7 other sector kept", v, 8'h1A);
   endtask

   task automatic t_chip_erase();
      int cyc; int k; logic [DW-1:0] v, arr; logic b;
      int fc [8]; logic [DW-1:0] fv [8]; logic [SW-1:0] fs [8];
      start_op(2'b11, 6'h00, 8'h00);
      cyc = 1; k = 0;
      while (busy_o && cyc < 500) begin
         if (arr_fill_o && k < 8) begin
            fc[k] = cyc; fv[k] = arr_fill_val_o; fs[k] = arr_sect_o; k++;
         end
         @(negedge clk);
         cyc++;
      end
      check(cyc - 1 == NS * (ZC + SC), "R8 chip length", cyc - 1, NS * (ZC + SC));
      check(k == 8, "R8 fill count", k, 8);
      for (int i = 0; i < 8; i++) begin
         int ec; logic [DW-1:0] ev; int es;
         ec = (i < NS) ? ZC * (i + 1) : NS * ZC + SC * (i - NS + 1);
         ev = (i < NS) ? 8'h00 : 8'hFF;
         es = (i < NS) ? i : i - NS;
         check(i < k && fc[i] == ec && fv[i] == ev && int'(fs[i]) == es,
               "R8 fill order", fc[i], ec);
      end
      do_read(6'h05, v, arr, b);
      check(v == 8'hFF, "R8 erased 05", v, 8'hFF);
      do_read(6'h3F, v, arr, b);
      check(v == 8'hFF, "R8 erased 3F", v, 8'hFF);
   endtask

   task automatic t_ignore_while_busy();
      logic [DW-1:0] v, arr, exp; logic b; int n;
      start_op(2'b10, 6'h30, 8'h00);
      do_read(6'h30, v, arr, b);
      exp = busy_view(arr, 1'b1, ~tgl_exp);
      check(b && v == exp, "R4 poll bit erase", v, exp);
      start_op(2'b01, 6'h31, 8'h00);
      wait_idle(n);
      check(n == 4, "R9 busy time unchanged", n, 4);
      @(negedge clk);
      check(!busy_o, "R9 no restart", busy_o, 0);
      do_read(6'h31, v, arr, b);
      check(v == 8'hFF, "R9 program ignored", v, 8'hFF);
   endtask

   task automatic t_idle_reads();
      logic [DW-1:0] v1, v2, arr; logic b; int n;
      start_op(2'b01, 6'h0A, 8'hBF);
      wait_idle(n);
      do_read(6'h0A, v1, arr, b);
      do_read(6'h0A, v2, arr, b);
      check(v1 == 8'hBF, "R6 idle pass", v1, 8'hBF);
      check(v2 == v1, "R5 no toggle idle", v2, v1);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_nop();
      t_program_poll();
      t_prog_timing(6'h11, 8'h77, "R3");
      t_sector_erase();
      t_chip_erase();
      t_prog_timing(6'h08, 8'hF0, "R10 first");
      t_prog_timing(6'h09, 8'h0F, "R10 second");
      t_ignore_while_busy();
      t_idle_reads();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule